// File: doc/BRIEF.md
# Programmable Timer with Reload Delay

This block is an 8-bit up-counter whose count rate is taken from one of four taps of an external free-running divider. Each falling edge of the chosen divider bit, while the timer is enabled, adds one to the counter. When the counter passes 0xFF, it is loaded with a programmable modulo value. A short reload sequence then follows, and it issues a one-cycle interrupt request on the next step strobe after the wrap rather than on the wrap itself.

Software reaches the counter, the modulo value and a 3-bit control field through a small register port. Changing the control field can produce one extra increment. The counter watches the gated divider level (enable AND selected bit), and a control write that drops this level from 1 to 0 is treated as a falling edge. The interrupt output is registered and goes to an external interrupt-flag staging register.

Top module: `prog_timer`

## Requirements
- R1: After reset, the counter and the modulo register read 0x00, the control register reads 0xF8, and `timer_irq_o` is low.
- R2: Register addresses are 0 for the counter, 1 for the modulo value and 2 for control. Address 3 reads 0xFF. Writes take effect in the next cycle. Control keeps only data bits 2..0 and reads back with bits 7..3 set to one.
- R3: When control bit 2 is set, the counter rises by one on each falling edge of divider bit 9, 3, 5 or 7, for tap select (control bits 1..0) 0, 1, 2 or 3. With a divider that counts once per clock, the periods are 1024, 16, 64 and 256 clocks.
- R4: When control bit 2 is clear, divider activity leaves the counter unchanged.
- R5: An increment from 0xFF loads the modulo value into the counter in the next cycle. The interrupt output stays low in that cycle.
- R6: The first step strobe that comes in a cycle after the wrap raises `timer_irq_o` for exactly one cycle, the cycle after that strobe. A strobe in the wrap cycle itself does not count.
- R7: The next step strobe ends the reload sequence. Later strobes raise no interrupt until another wrap.
- R8: A control write causes one increment when the old setting had the timer enabled with its selected divider bit at 1, and the new setting is disabled or selects a divider bit at 0. A control write from a gated level of 0 causes no increment.
- R9: A counter write in the same cycle as an increment wins. The written value is stored, no reload takes place and no interrupt follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Free-running divider value |
| step_i | input | 1 | Step strobe that advances the reload sequence |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| timer_irq_o | output | 1 | One-cycle timer interrupt request |

## Verification
The hardest situations to reach are those where a register write lands in the same cycle as a divider edge. Examples are a control rewrite that drops the gated level, and a counter write that meets the wrap from 0xFF. A free-running divider hits these only by chance. For the directed cases, the bench therefore drives the divider itself and holds it at chosen values, such as bit 3 set with bits 5, 7 and 9 clear, so that each case falls on a known cycle. A random phase with a per-cycle reference model then mixes writes, steps and wraps.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned CTRL_W = 3;
    localparam int unsigned NTAPS  = 4;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_MOD   = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    // reload sequence; RS_RUNNING must be the reset encoding
    typedef enum logic [1:0] {
        RS_RUNNING   = 2'd0,
        RS_RELOADING = 2'd1,
        RS_RELOADED  = 2'd2
    } reload_e;

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] modv;
        logic [CTRL_W-1:0] ctrl;
        logic              lvl;   // gated tap level seen last cycle
    } tmr_regs_t;

endpackage

// File: rtl/ptmr_tap_mux.sv
module ptmr_tap_mux
    import prog_timer_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned TAP_POS [NTAPS] = '{9, 3, 5, 7}
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [1:0]       sel_i,
    output logic             bit_o
);

    logic [NTAPS-1:0] taps;
    logic             div_unused;

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        assign taps[i] = div_i[TAP_POS[i]];
    end

    assign div_unused = ^div_i;
    assign bit_o      = taps[sel_i];

endmodule

// File: rtl/ptmr_reload_seq.sv
module ptmr_reload_seq
    import prog_timer_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    step_i,
    input  logic    load_i,
    output reload_e state_o,
    output logic    irq_o
);

    typedef struct packed {
        reload_e st;
        logic    irq;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = step_i && (seq_q.st == RS_RELOADING);
        if (load_i) begin
            seq_d.st = RS_RELOADING;
        end else if (step_i) begin
            case (seq_q.st)
                RS_RELOADING: seq_d.st = RS_RELOADED;
                RS_RELOADED:  seq_d.st = RS_RUNNING;
                default:      seq_d.st = seq_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: RS_RUNNING, irq: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;
    assign irq_o   = seq_q.irq;

    // a request only follows a step taken while reloading
    assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.irq |-> ($past(seq_q.st) == RS_RELOADING && $past(step_i)));

    // the step after the request ends the sequence
    assert_seq_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.st == RS_RELOADED && step_i && !load_i) |=> (seq_q.st == RS_RUNNING));

    // a wrap always restarts the sequence and never fires in its own cycle
    assert_wrap_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (seq_q.st == RS_RELOADING && !seq_q.irq));

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import prog_timer_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned TAP_POS [NTAPS] = '{9, 3, 5, 7}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              step_i,
    input  logic              reg_we_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              timer_irq_o
);

    localparam logic [DATA_W-1:0] CNT_MAX   = '1;
    localparam logic [DATA_W-1:0] CTRL_FILL = ~DATA_W'((1 << CTRL_W) - 1);

    tmr_regs_t         r_d, r_q;
    logic              cnt_wr, mod_wr, ctrl_wr;
    logic [CTRL_W-1:0] ctrl_eff;
    logic              tap_bit, lvl_now, inc, load;
    reload_e           rl_state;

    assign cnt_wr  = reg_we_i && (reg_addr_i == ADDR_COUNT);
    assign mod_wr  = reg_we_i && (reg_addr_i == ADDR_MOD);
    assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);

    // a control write is seen by the edge detector in its own cycle
    assign ctrl_eff = ctrl_wr ? reg_wdata_i[CTRL_W-1:0] : r_q.ctrl;

    ptmr_tap_mux #(
        .DIV_W   (DIV_W),
        .TAP_POS (TAP_POS)
    ) u_tap (
        .div_i (div_i),
        .sel_i (ctrl_eff[1:0]),
        .bit_o (tap_bit)
    );

    assign lvl_now = ctrl_eff[2] & tap_bit;
    assign inc     = r_q.lvl & ~lvl_now;

    always_comb begin
        r_d     = r_q;
        r_d.lvl = lvl_now;
        load    = 1'b0;
        if (cnt_wr) begin
            r_d.cnt = reg_wdata_i;
        end else if (inc) begin
            if (r_q.cnt == CNT_MAX) begin
                r_d.cnt = r_q.modv;
                load    = 1'b1;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
        if (mod_wr) begin
            r_d.modv = reg_wdata_i;
        end
        if (ctrl_wr) begin
            r_d.ctrl = reg_wdata_i[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    ptmr_reload_seq u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (step_i),
        .load_i  (load),
        .state_o (rl_state),
        .irq_o   (timer_irq_o)
    );

    always_comb begin
        case (reg_addr_i)
            ADDR_COUNT: reg_rdata_o = r_q.cnt;
            ADDR_MOD:   reg_rdata_o = r_q.modv;
            ADDR_CTRL:  reg_rdata_o = CTRL_FILL | DATA_W'(r_q.ctrl);
            default:    reg_rdata_o = '1;
        endcase
    end

    // wrap from the top value takes the modulo held before the edge
    assert_wrap_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc && !cnt_wr && r_q.cnt == CNT_MAX) |=>
            (r_q.cnt == $past(r_q.modv) && rl_state == RS_RELOADING));

    // disabled and untouched: the count holds
    assert_hold_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!r_q.ctrl[2] && !reg_we_i) |=> $stable(r_q.cnt));

    // a counter write beats a coincident increment
    assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (r_q.cnt == $past(reg_wdata_i)));

    // the count moves by at most one unless written or wrapped
    assert_step_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_wr && r_q.cnt != CNT_MAX) |=>
            (r_q.cnt == $past(r_q.cnt) || r_q.cnt == $past(r_q.cnt) + 1'b1));

endmodule

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div = '0;
    logic        step = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    prog_timer u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .div_i       (div),
        .step_i      (step),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .timer_irq_o (irq)
    );

    int    vectors = 0;
    int    fails = 0;
    string phase_req = "R1";

    // reference model built from the requirements
    logic [7:0] m_cnt, m_mod;
    logic [2:0] m_ctrl;
    logic       m_lvl, m_irq;
    int         m_state; // 0 running, 1 reloading, 2 reloaded

    function automatic logic tap_of(logic [15:0] d, logic [1:0] s);
        case (s)
            2'd0: return d[9];
            2'd1: return d[3];
            2'd2: return d[5];
            default: return d[7];
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_mod;
            2'd2: return {5'h1F, m_ctrl};
            default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [2:0] ce;
        logic       lv, wrap;
        if (!rst_n) begin
            m_cnt = 0; m_mod = 0; m_ctrl = 0; m_lvl = 0; m_irq = 0; m_state = 0;
        end else begin
            ce   = (we && addr == 2'd2) ? wdata[2:0] : m_ctrl;
            lv   = ce[2] & tap_of(div, ce[1:0]);
            wrap = 1'b0;
            m_irq = step && (m_state == 1);
            if (we && addr == 2'd0) m_cnt = wdata;
            else if (m_lvl && !lv) begin
                if (m_cnt == 8'hFF) begin m_cnt = m_mod; wrap = 1'b1; end
                else m_cnt = m_cnt + 8'd1;
            end
            m_lvl = lv;
            if (we && addr == 2'd1) m_mod = wdata;
            if (we && addr == 2'd2) m_ctrl = wdata[2:0];
            if (wrap) m_state = 1;
            else if (step && m_state == 1) m_state = 2;
            else if (step && m_state == 2) m_state = 0;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one clock; compares outputs against the model away from the edge
    task automatic tick();
        @(negedge clk);
        chk(phase_req, rdata, exp_rd(addr));
        chk(phase_req, {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
        we = 1'b0; addr = a;
        tick();
        chk(req, rdata, exp);
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        int periods [4];
        periods = '{1024, 16, 64, 256};
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;

        // R1 reset values
        phase_req = "R1";
        rd_chk(2'd0, 8'h00, "R1");
        rd_chk(2'd1, 8'h00, "R1");
        rd_chk(2'd2, 8'hF8, "R1");
        chk("R1", {7'd0, irq}, 8'h00);

        // R2 register map
        phase_req = "R2";
        rd_chk(2'd3, 8'hFF, "R2");
        wr(2'd1, 8'hA5); rd_chk(2'd1, 8'hA5, "R2");
        wr(2'd2, 8'hFA); rd_chk(2'd2, 8'hFA, "R2");
        wr(2'd0, 8'h3C); rd_chk(2'd0, 8'h3C, "R2");

        // R4 disabled: divider runs, count holds
        phase_req = "R4";
        for (int i = 0; i < 300; i++) begin div = div + 16'd1; tick(); end
        rd_chk(2'd0, 8'h3C, "R4");

        // R3 each tap: four periods from an aligned divider give four counts
        phase_req = "R3";
        for (int s = 0; s < 4; s++) begin
            div = 16'd0;
            wr(2'd0, 8'h00);
            wr(2'd2, 8'h04 | 8'(s));
            for (int i = 0; i < 4 * periods[s]; i++) begin div = div + 16'd1; tick(); end
            rd_chk(2'd0, 8'h04, "R3");
        end

        // R5 wrap loads modulo, no request yet
        phase_req = "R5";
        wr(2'd1, 8'h80); wr(2'd2, 8'h05); div = 16'd0; wr(2'd0, 8'hFF);
        div = 16'd8; tick();
        div = 16'd16; tick();
        rd_chk(2'd0, 8'h80, "R5");
        chk("R5", {7'd0, irq}, 8'h00);

        // R6 first step raises one pulse, R7 next step ends the sequence
        phase_req = "R6";
        step = 1'b1; tick(); chk("R6", {7'd0, irq}, 8'h01);
        step = 1'b0; tick(); chk("R6", {7'd0, irq}, 8'h00);
        phase_req = "R7";
        step = 1'b1; tick(); chk("R7", {7'd0, irq}, 8'h00);
        tick(); chk("R7", {7'd0, irq}, 8'h00);
        step = 1'b0; tick();

        // R6 a step in the wrap cycle itself is not the first step
        phase_req = "R6";
        wr(2'd0, 8'hFF);
        div = 16'd8; tick();
        div = 16'd16; step = 1'b1; tick(); chk("R6", {7'd0, irq}, 8'h00);
        tick(); chk("R6", {7'd0, irq}, 8'h01);
        tick(); step = 1'b0; tick();

        // R8 control rewrite glitch (div = 8: bit3 high, bits 5,7,9 low)
        phase_req = "R8";
        div = 16'd8; wr(2'd2, 8'h05); wr(2'd0, 8'h40);
        wr(2'd2, 8'h04); rd_chk(2'd0, 8'h41, "R8");
        wr(2'd2, 8'h05); rd_chk(2'd0, 8'h41, "R8");
        wr(2'd2, 8'h01); rd_chk(2'd0, 8'h42, "R8");
        wr(2'd2, 8'h06); rd_chk(2'd0, 8'h42, "R8");
        wr(2'd2, 8'h05); wr(2'd2, 8'h05); rd_chk(2'd0, 8'h42, "R8");

        // R9 counter write meets the wrap edge
        phase_req = "R9";
        wr(2'd0, 8'hFF);
        div = 16'd16; we = 1'b1; addr = 2'd0; wdata = 8'h12; tick(); we = 1'b0;
        rd_chk(2'd0, 8'h12, "R9");
        step = 1'b1; tick(); tick(); chk("R9", {7'd0, irq}, 8'h00);
        step = 1'b0;

        // random mix against the model
        phase_req = "R7";
        wr(2'd1, 8'hF8); wr(2'd2, 8'h05);
        for (int i = 0; i < 4000; i++) begin
            div  = div + 16'd1;
            step = ($urandom % 3) == 0;
            we   = ($urandom % 12) == 0;
            addr = we ? 2'($urandom % 3) : 2'($urandom % 4);
            case (addr)
                2'd1:    wdata = 8'hF0 | 8'($urandom % 16);
                2'd2:    wdata = (($urandom % 5) == 0) ? 8'($urandom % 8) : (8'h04 | 8'($urandom % 4));
                default: wdata = 8'($urandom);
            endcase
            tick();
        end
        we = 1'b0; step = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule